// File: doc/BRIEF.md
# Asymmetric Width Dual-Port RAM

This block is a single-clock memory of 2048 bits that two ports see at different widths. The wide port reads and writes 256 words of 8 bits. The narrow port reads and writes 512 words of 4 bits. Both ports reach the same bits. Internally the bits are split into two 4-bit banks. The even bank holds the even narrow addresses and the odd bank holds the odd ones. A wide word therefore covers one row of each bank.

Each port has its own address, write enable and write data. Each port also has a registered read output with a latency of one clock. Use the block as a width converter. One agent fills the memory a byte at a time while another drains it a nibble at a time, or the other way round. The wide word's most significant nibble always comes first on the narrow side.

Top module: `asym_ram`

## Requirements
- R1: While `rst` is sampled high at a rising edge, both read outputs become 0 at that edge.
- R2: A wide write stores `a_wdata` at word `a_addr`. A wide read returns that word on the rising edge after the address is presented.
- R3: A narrow write stores `b_wdata` at `b_addr`. A narrow read returns that nibble on the rising edge after the address is presented.
- R4: Wide word n bits 7:4 sit at narrow address {n,0} (even), and bits 3:0 sit at narrow address {n,1} (odd).
- R5: `a_rdata` is the even-address nibble in bits 7:4 followed by the odd-address nibble in bits 3:0, so narrow writes are visible to the wide port.
- R6: One wide write updates both nibbles of its pair at the same clock edge.
- R7: A wide read of the word being written by the wide port in the same cycle returns the previous contents (read-first).
- R8: A read on either port of a location written in the same cycle, by either port, returns the previous contents.
- R9: When both ports write the same nibble in one cycle, the narrow port's data is kept for that nibble. The wide port's other nibble is still written.
- R10: When both ports write disjoint locations in one cycle, both writes take effect.
- R11: Reset does not alter the stored contents. Data written before a reset reads back unchanged after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous active-high reset of the read outputs |
| a_addr | input | 8 | Wide port word address |
| a_we | input | 1 | Wide port write enable |
| a_wdata | input | 8 | Wide port write data |
| a_rdata | output | 8 | Wide port registered read data |
| b_addr | input | 9 | Narrow port nibble address |
| b_we | input | 1 | Narrow port write enable |
| b_wdata | input | 4 | Narrow port write data |
| b_rdata | output | 4 | Narrow port registered read data |

## Verification
The main function is exercised with several kinds of traffic. Wide writes are read back through both narrow addresses, which separates the even-high nibble order from a swapped one. Narrow writes to an even and an odd address are read as one wide word, which exposes a wrong concatenation. Repeated writes to the same location, with reads in the same cycle, tell read-first behaviour apart from write-first. Simultaneous writes to an even nibble, to an odd nibble and to unrelated rows show which port wins a collision. They also show whether the losing port's other nibble survives.

// File: rtl/asym_ram_pkg.sv
package asym_ram_pkg;

    parameter int A_AW  = 8;
    parameter int NIB_W = 4;

    localparam int NIBS = 2;
    localparam int B_AW = A_AW + 1;
    localparam int A_DW = NIB_W * NIBS;
    localparam int ROWS = 2 ** A_AW;

    typedef logic [A_AW-1:0]  row_t;
    typedef logic [B_AW-1:0]  baddr_t;
    typedef logic [NIB_W-1:0] nib_t;
    typedef logic [A_DW-1:0]  word_t;

    typedef struct packed {
        logic en;
        row_t row;
        nib_t data;
    } nib_wr_t;

    typedef struct packed {
        row_t row;
        logic lane;
    } bloc_t;

    function automatic bloc_t split_baddr(input baddr_t a);
        bloc_t r;
        r.row  = a[B_AW-1:1];
        r.lane = a[0];
        return r;
    endfunction

    // lane 0 (even narrow address) carries the upper half of a wide word
    function automatic nib_t word_nib(input word_t w, input logic lane);
        return lane ? w[NIB_W-1:0] : w[A_DW-1:NIB_W];
    endfunction

    function automatic word_t join_nibs(input nib_t even_n, input nib_t odd_n);
        return {even_n, odd_n};
    endfunction

endpackage

// File: rtl/asym_nibble_bank.sv
module asym_nibble_bank
    import asym_ram_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  nib_wr_t wr_a,
    input  nib_wr_t wr_b,
    input  row_t    rd_row_a,
    input  row_t    rd_row_b,
    output nib_t    q_a,
    output nib_t    q_b
);

    nib_t mem [ROWS];

    // second statement wins when both target the same row
    always_ff @(posedge clk) begin
        if (wr_a.en) mem[wr_a.row] <= wr_a.data;
        if (wr_b.en) mem[wr_b.row] <= wr_b.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_a <= '0;
            q_b <= '0;
        end else begin
            q_a <= mem[rd_row_a];
            q_b <= mem[rd_row_b];
        end
    end

endmodule

// File: rtl/asym_a_side.sv
module asym_a_side
    import asym_ram_pkg::*;
(
    input  row_t                     a_addr,
    input  logic                     a_we,
    input  word_t                    a_wdata,
    output nib_wr_t [NIBS-1:0]       wr_o,
    input  nib_t    [NIBS-1:0]       q_i,
    output word_t                    a_rdata
);

    for (genvar g = 0; g < NIBS; g++) begin : g_lane
        always_comb begin
            wr_o[g].en   = a_we;
            wr_o[g].row  = a_addr;
            wr_o[g].data = word_nib(a_wdata, 1'(g));
        end
    end

    assign a_rdata = join_nibs(q_i[0], q_i[1]);

endmodule

// File: rtl/asym_b_side.sv
module asym_b_side
    import asym_ram_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  baddr_t                   b_addr,
    input  logic                     b_we,
    input  nib_t                     b_wdata,
    output nib_wr_t [NIBS-1:0]       wr_o,
    output row_t                     row_o,
    input  nib_t    [NIBS-1:0]       q_i,
    output nib_t                     b_rdata
);

    bloc_t loc;
    logic  lane_q;

    assign loc   = split_baddr(b_addr);
    assign row_o = loc.row;

    for (genvar g = 0; g < NIBS; g++) begin : g_lane
        always_comb begin
            wr_o[g].en   = b_we && (loc.lane == 1'(g));
            wr_o[g].row  = loc.row;
            wr_o[g].data = b_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) lane_q <= 1'b0;
        else     lane_q <= loc.lane;
    end

    assign b_rdata = q_i[lane_q];

endmodule

// File: rtl/asym_ram.sv
module asym_ram
    import asym_ram_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [A_AW-1:0]      a_addr,
    input  logic                 a_we,
    input  logic [A_DW-1:0]      a_wdata,
    output logic [A_DW-1:0]      a_rdata,
    input  logic [B_AW-1:0]      b_addr,
    input  logic                 b_we,
    input  logic [NIB_W-1:0]     b_wdata,
    output logic [NIB_W-1:0]     b_rdata
);

    nib_wr_t [NIBS-1:0] a_wr;
    nib_wr_t [NIBS-1:0] b_wr;
    nib_t    [NIBS-1:0] qa;
    nib_t    [NIBS-1:0] qb;
    row_t               b_row;

    asym_a_side u_a (
        .a_addr  (a_addr),
        .a_we    (a_we),
        .a_wdata (a_wdata),
        .wr_o    (a_wr),
        .q_i     (qa),
        .a_rdata (a_rdata)
    );

    asym_b_side u_b (
        .clk     (clk),
        .rst     (rst),
        .b_addr  (b_addr),
        .b_we    (b_we),
        .b_wdata (b_wdata),
        .wr_o    (b_wr),
        .row_o   (b_row),
        .q_i     (qb),
        .b_rdata (b_rdata)
    );

    for (genvar g = 0; g < NIBS; g++) begin : g_bank
        asym_nibble_bank u_bank (
            .clk      (clk),
            .rst      (rst),
            .wr_a     (a_wr[g]),
            .wr_b     (b_wr[g]),
            .rd_row_a (a_addr),
            .rd_row_b (b_row),
            .q_a      (qa[g]),
            .q_b      (qb[g])
        );
    end

endmodule

// File: rtl/asym_ram_chk.sv
module asym_ram_chk
    import asym_ram_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [A_AW-1:0]   a_addr,
    input logic              a_we,
    input logic [A_DW-1:0]   a_wdata,
    input logic [A_DW-1:0]   a_rdata,
    input logic [B_AW-1:0]   b_addr,
    input logic              b_we,
    input logic [NIB_W-1:0]  b_wdata,
    input logic [NIB_W-1:0]  b_rdata
);

    // R1
    rst_clears_chk: assert property (@(posedge clk)
        rst |=> (a_rdata == '0 && b_rdata == '0));

    // R4
    a_to_b_even_chk: assert property (@(posedge clk) disable iff (rst)
        (a_we && !b_we) ##1 (!a_we && !b_we && b_addr == {$past(a_addr), 1'b0})
        |=> b_rdata == word_nib($past(a_wdata, 2), 1'b0));

    // R6
    a_to_b_odd_chk: assert property (@(posedge clk) disable iff (rst)
        (a_we && !b_we) ##1 (!a_we && !b_we && b_addr == {$past(a_addr), 1'b1})
        |=> b_rdata == word_nib($past(a_wdata, 2), 1'b1));

    // R5
    b_to_a_chk: assert property (@(posedge clk) disable iff (rst)
        (b_we && !a_we) ##1 (!a_we && !b_we && a_addr == $past(b_addr[B_AW-1:1]))
        |=> word_nib(a_rdata, $past(b_addr[0], 2)) == $past(b_wdata, 2));

    // R7
    a_read_first_chk: assert property (@(posedge clk) disable iff (rst)
        (a_we && !b_we) ##1 (a_we && !b_we && a_addr == $past(a_addr))
        |=> a_rdata == $past(a_wdata, 2));

    // R9
    collide_chk: assert property (@(posedge clk) disable iff (rst)
        (a_we && b_we && b_addr[B_AW-1:1] == a_addr)
        ##1 (!a_we && !b_we && a_addr == $past(a_addr))
        |=> (word_nib(a_rdata, $past(b_addr[0], 2)) == $past(b_wdata, 2)) &&
            (word_nib(a_rdata, !$past(b_addr[0], 2)) ==
             word_nib($past(a_wdata, 2), !$past(b_addr[0], 2))));

endmodule

bind asym_ram asym_ram_chk u_chk (.*);

// File: tb/tb_asym_ram.sv
module tb_asym_ram;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] a_addr = '0;
    logic       a_we = 1'b0;
    logic [7:0] a_wdata = '0;
    logic [7:0] a_rdata;
    logic [8:0] b_addr = '0;
    logic       b_we = 1'b0;
    logic [3:0] b_wdata = '0;
    logic [3:0] b_rdata;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;

    asym_ram dut (
        .clk(clk), .rst(rst),
        .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_addr(b_addr), .b_we(b_we), .b_wdata(b_wdata), .b_rdata(b_rdata)
    );

    always #5 clk = ~clk;

    // fields: a_we a_addr a_wdata | b_we b_addr b_wdata | chk_a exp_a | chk_b exp_b | req
    localparam int NV = 17;
    localparam logic [48:0] TBL [NV] = '{
        {1'b1, 8'h10, 8'hA5, 1'b0, 9'h000, 4'h0, 1'b0, 8'h00, 1'b0, 4'h0, 4'd2},  // R2 write
        {1'b0, 8'h10, 8'h00, 1'b0, 9'h020, 4'h0, 1'b1, 8'hA5, 1'b1, 4'hA, 4'd4},  // R2 R4 even
        {1'b0, 8'h00, 8'h00, 1'b0, 9'h021, 4'h0, 1'b0, 8'h00, 1'b1, 4'h5, 4'd4},  // R4 odd
        {1'b0, 8'h00, 8'h00, 1'b1, 9'h041, 4'h3, 1'b0, 8'h00, 1'b0, 4'h0, 4'd3},  // R3
        {1'b0, 8'h00, 8'h00, 1'b1, 9'h040, 4'hC, 1'b0, 8'h00, 1'b0, 4'h0, 4'd3},  // R3
        {1'b0, 8'h20, 8'h00, 1'b0, 9'h041, 4'h0, 1'b1, 8'hC3, 1'b1, 4'h3, 4'd5},  // R5 R3
        {1'b1, 8'h30, 8'h12, 1'b0, 9'h000, 4'h0, 1'b0, 8'h00, 1'b0, 4'h0, 4'd7},  // R7 first
        {1'b1, 8'h30, 8'h34, 1'b0, 9'h000, 4'h0, 1'b1, 8'h12, 1'b0, 4'h0, 4'd7},  // R7 old value
        {1'b0, 8'h30, 8'h00, 1'b0, 9'h061, 4'h0, 1'b1, 8'h34, 1'b1, 4'h4, 4'd6},  // R6
        {1'b0, 8'h30, 8'h00, 1'b1, 9'h061, 4'h9, 1'b1, 8'h34, 1'b1, 4'h4, 4'd8},  // R8 old on both
        {1'b0, 8'h30, 8'h00, 1'b0, 9'h061, 4'h0, 1'b1, 8'h39, 1'b1, 4'h9, 4'd8},  // R8 new
        {1'b1, 8'h50, 8'h77, 1'b1, 9'h0A0, 4'hE, 1'b0, 8'h00, 1'b0, 4'h0, 4'd9},  // R9 even clash
        {1'b0, 8'h50, 8'h00, 1'b0, 9'h0A1, 4'h0, 1'b1, 8'hE7, 1'b1, 4'h7, 4'd9},  // R9
        {1'b1, 8'h51, 8'h88, 1'b1, 9'h0A3, 4'h1, 1'b0, 8'h00, 1'b0, 4'h0, 4'd9},  // R9 odd clash
        {1'b0, 8'h51, 8'h00, 1'b0, 9'h0A2, 4'h0, 1'b1, 8'h81, 1'b1, 4'h8, 4'd9},  // R9
        {1'b1, 8'h60, 8'hBD, 1'b1, 9'h001, 4'h6, 1'b0, 8'h00, 1'b0, 4'h0, 4'd10}, // R10 disjoint
        {1'b0, 8'h60, 8'h00, 1'b0, 9'h001, 4'h0, 1'b1, 8'hBD, 1'b1, 4'h6, 4'd10}  // R10
    };

    task automatic chk_a(input logic [7:0] exp, input int req);
        n_run++;
        if (a_rdata !== exp) begin
            n_fail++;
            $display("FAIL R%0d a_rdata actual %h expected %h", req, a_rdata, exp);
        end
    endtask

    task automatic chk_b(input logic [3:0] exp, input int req);
        n_run++;
        if (b_rdata !== exp) begin
            n_fail++;
            $display("FAIL R%0d b_rdata actual %h expected %h", req, b_rdata, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1: outputs cleared while reset is high
        chk_a(8'h00, 1);
        chk_b(4'h0, 1);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [48:0] v;
            v = TBL[i];
            a_we    = v[48];
            a_addr  = v[47:40];
            a_wdata = v[39:32];
            b_we    = v[31];
            b_addr  = v[30:22];
            b_wdata = v[21:18];
            @(negedge clk);
            if (v[17]) chk_a(v[16:9], int'(v[3:0]));
            if (v[8])  chk_b(v[7:4], int'(v[3:0]));
        end

        // R1 directed: reset mid-run clears outputs
        a_we = 1'b0; b_we = 1'b0;
        a_addr = 8'h60; b_addr = 9'h001;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk_a(8'h00, 1);
        chk_b(4'h0, 1);
        rst = 1'b0;
        // R11: contents survive reset
        @(negedge clk);
        chk_a(8'hBD, 11);
        chk_b(4'h6, 11);
        // R11: earlier narrow-written word also intact
        a_addr = 8'h20; b_addr = 9'h040;
        @(negedge clk);
        chk_a(8'hC3, 11);
        chk_b(4'hC, 11);

        finish_run();
    end

endmodule